// File: doc/BRIEF.md
# Descriptor Chain Bus Error Sequencer

This block steps a chain of command descriptors through four phases per descriptor: fetching the descriptor, synchronising, executing the command and writing the descriptor's status back. Each phase ends when the master bus side returns a response. A response can report a clean finish, a bus error, or a corrupted descriptor image during fetch. The block decides from the phase and a continue-on-error control bit whether the rest of the chain is dropped or whether execution goes on. It presents the Bus Error, Fail and format-error flags to be written into the current descriptor's status. It also sends a one-cycle error event, with the faulting address and phase, to the interrupt logic.

A fault while fetching or synchronising always ends the chain, because the controller can no longer trust what it read from the system side. A fault while executing or writing status obeys the continue-on-error bit. A fault during the status write is not written into any descriptor. It shows up only as a pulse meant for the controller's own status. When the chain ends, the block gives a done pulse and an aborted flag that holds until the next chain begins.

Top module: `chain_err_sequencer`

## Requirements
- R1: After reset, phase is IDLE (code 0), and err_evt, stwr_err, chain_done, aborted and all status flags are 0.
- R2: Phase codes are IDLE=0, FETCH=1, SYNC=2, EXEC=3, STATUS_WR=4, DONE_ABORT=5. A chain_start in IDLE moves phase to FETCH on the next edge. A clean response (rsp_valid=1, rsp_err=0, rsp_fmt_err=0) advances FETCH to SYNC, SYNC to EXEC and EXEC to STATUS_WR.
- R3: A clean response in STATUS_WR with no kill pending goes to FETCH if desc_avail=1. Otherwise it goes to IDLE with a one-cycle chain_done and aborted=0.
- R4: A bus error response in FETCH or SYNC moves phase straight to STATUS_WR with stat_bus_err=1 and stat_fail=1. The status write that follows then goes to DONE_ABORT, whatever cont_on_err is.
- R5: A bus error response in EXEC moves to STATUS_WR with stat_bus_err=1 and stat_fail=1. Leaving STATUS_WR then goes to DONE_ABORT if cont_on_err was 0 at the error. If cont_on_err was 1, the chain continues as in R3.
- R6: A bus error response in STATUS_WR gives a one-cycle stwr_err and does not repeat the status write. Phase goes to DONE_ABORT if cont_on_err=0 or a kill is already pending; otherwise it continues as in R3.
- R7: Each bus error response in an active phase gives err_evt=1 for exactly the next cycle. err_evt_addr carries rsp_addr and err_evt_phase carries the phase code in which the error occurred.
- R8: A response with rsp_err=0 and rsp_fmt_err=1 in FETCH moves to STATUS_WR with stat_fail=1, stat_fmt_err=1 and stat_bus_err=0. It raises no err_evt and always leads to DONE_ABORT. rsp_fmt_err is ignored in other phases and when rsp_err=1.
- R9: DONE_ABORT lasts one cycle and then goes to IDLE. chain_done pulses in the first cycle of DONE_ABORT. aborted becomes 1 there and stays 1 until the next accepted chain_start moves phase to FETCH.
- R10: The status flags clear whenever phase enters FETCH. rsp_valid in IDLE or DONE_ABORT has no effect, and chain_start outside IDLE has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_start | input | 1 | Begin a new chain (accepted in IDLE) |
| desc_avail | input | 1 | Another descriptor follows the current one |
| cont_on_err | input | 1 | Continue the chain after execute or status-write errors |
| rsp_valid | input | 1 | Current phase's bus response is present |
| rsp_err | input | 1 | Response carries a bus error |
| rsp_fmt_err | input | 1 | Fetched descriptor image is malformed |
| rsp_addr | input | AW | Address of the transfer that responded |
| phase | output | 3 | Current phase code |
| stat_bus_err | output | 1 | Bus Error flag for the descriptor status |
| stat_fail | output | 1 | Fail flag for the descriptor status |
| stat_fmt_err | output | 1 | Descriptor/command format error flag |
| stwr_err | output | 1 | One-cycle pulse: status write failed |
| err_evt | output | 1 | One-cycle error event toward interrupt logic |
| err_evt_addr | output | AW | Faulting address of the event |
| err_evt_phase | output | 3 | Phase code in which the error occurred |
| chain_done | output | 1 | One-cycle pulse when the chain ends |
| aborted | output | 1 | Last chain ended by abort |

## Verification
The assertions check the per-cycle rules on every cycle. An early-phase error must land in STATUS_WR with Bus Error and Fail set. A pending kill must turn the status write into DONE_ABORT. DONE_ABORT must last exactly one cycle. Every err_evt and stwr_err must trace back to an error response in the cycle before. Only the bench's scenarios can show the outcomes of whole chains. These include the cont_on_err choice after an execute error, the continuation into a following descriptor with cleared flags, the exact event address, and aborted holding across idle time until a new chain starts.

// File: rtl/ces_pkg.sv
package ces_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FETCH = 3'd1,
    PH_SYNC  = 3'd2,
    PH_EXEC  = 3'd3,
    PH_STWR  = 3'd4,
    PH_ABORT = 3'd5
  } phase_e;

  // A phase in which a bus response is expected.
  function automatic logic is_busy(phase_e ph);
    return (ph == PH_FETCH) || (ph == PH_SYNC) || (ph == PH_EXEC) || (ph == PH_STWR);
  endfunction

  // Early phases always kill the chain; later phases obey the control bit.
  function automatic logic err_kills(phase_e ph, logic cont);
    if ((ph == PH_FETCH) || (ph == PH_SYNC)) return 1'b1;
    return !cont;
  endfunction

  // Successor of a phase on a clean response (STATUS_WR handled separately).
  function automatic phase_e step_ok(phase_e ph);
    case (ph)
      PH_FETCH: return PH_SYNC;
      PH_SYNC:  return PH_EXEC;
      PH_EXEC:  return PH_STWR;
      default:  return ph;
    endcase
  endfunction

endpackage

// File: rtl/ces_resp_decode.sv
module ces_resp_decode
  import ces_pkg::*;
(
  input  phase_e phase_q,
  input  logic   rsp_valid,
  input  logic   rsp_err,
  input  logic   rsp_fmt_err,
  input  logic   cont_on_err,
  output logic   ev_ok,
  output logic   ev_bus_err,
  output logic   ev_fmt_err,
  output logic   ev_stwr_err,
  output logic   ev_kill
);

  logic accept;

  always_comb begin
    accept      = rsp_valid && is_busy(phase_q);
    ev_bus_err  = accept && rsp_err && (phase_q != PH_STWR);
    ev_stwr_err = accept && rsp_err && (phase_q == PH_STWR);
    ev_fmt_err  = accept && !rsp_err && rsp_fmt_err && (phase_q == PH_FETCH);
    ev_ok       = accept && !rsp_err && !ev_fmt_err;
    ev_kill     = (ev_bus_err || ev_stwr_err) && err_kills(phase_q, cont_on_err);
  end

endmodule

// File: rtl/ces_phase_fsm.sv
module ces_phase_fsm
  import ces_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   chain_start,
  input  logic   desc_avail,
  input  logic   ev_ok,
  input  logic   ev_bus_err,
  input  logic   ev_fmt_err,
  input  logic   ev_stwr_err,
  input  logic   ev_kill,
  input  logic   kill_pend,
  output phase_e phase_q,
  output logic   start_acc,
  output logic   desc_begin,
  output logic   end_clean,
  output logic   end_abort
);

  phase_e phase_d;
  logic   leave_stwr;
  logic   stop_now;

  always_comb begin
    phase_d    = phase_q;
    start_acc  = 1'b0;
    end_clean  = 1'b0;
    end_abort  = 1'b0;
    leave_stwr = (phase_q == PH_STWR) && (ev_ok || ev_stwr_err);
    stop_now   = kill_pend || ev_kill;
    case (phase_q)
      PH_IDLE: begin
        if (chain_start) begin
          phase_d   = PH_FETCH;
          start_acc = 1'b1;
        end
      end
      PH_FETCH, PH_SYNC, PH_EXEC: begin
        if (ev_bus_err || ev_fmt_err) phase_d = PH_STWR;
        else if (ev_ok)               phase_d = step_ok(phase_q);
      end
      PH_STWR: begin
        if (leave_stwr) begin
          if (stop_now) begin
            phase_d   = PH_ABORT;
            end_abort = 1'b1;
          end else if (desc_avail) begin
            phase_d = PH_FETCH;
          end else begin
            phase_d   = PH_IDLE;
            end_clean = 1'b1;
          end
        end
      end
      PH_ABORT: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
    desc_begin = (phase_d == PH_FETCH) && (phase_q != PH_FETCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/ces_status_track.sv
module ces_status_track
  import ces_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic desc_begin,
  input  logic ev_bus_err,
  input  logic ev_fmt_err,
  input  logic ev_kill,
  output logic stat_bus_err,
  output logic stat_fail,
  output logic stat_fmt_err,
  output logic kill_pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_bus_err <= 1'b0;
      stat_fail    <= 1'b0;
      stat_fmt_err <= 1'b0;
      kill_pend    <= 1'b0;
    end else if (desc_begin) begin
      stat_bus_err <= 1'b0;
      stat_fail    <= 1'b0;
      stat_fmt_err <= 1'b0;
      kill_pend    <= 1'b0;
    end else if (ev_bus_err) begin
      stat_bus_err <= 1'b1;
      stat_fail    <= 1'b1;
      kill_pend    <= kill_pend || ev_kill;
    end else if (ev_fmt_err) begin
      stat_fail    <= 1'b1;
      stat_fmt_err <= 1'b1;
      kill_pend    <= 1'b1;
    end
  end

endmodule

// File: rtl/ces_err_event.sv
module ces_err_event
  import ces_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_bus_err,
  input  logic          ev_stwr_err,
  input  phase_e        phase_q,
  input  logic [AW-1:0] rsp_addr,
  output logic          err_evt,
  output logic [AW-1:0] err_evt_addr,
  output logic [2:0]    err_evt_phase,
  output logic          stwr_err
);

  logic fire;
  assign fire = ev_bus_err || ev_stwr_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_evt       <= 1'b0;
      err_evt_addr  <= '0;
      err_evt_phase <= 3'd0;
      stwr_err      <= 1'b0;
    end else begin
      err_evt  <= fire;
      stwr_err <= ev_stwr_err;
      if (fire) begin
        err_evt_addr  <= rsp_addr;
        err_evt_phase <= phase_q;
      end
    end
  end

endmodule

// File: rtl/chain_err_sequencer.sv
module chain_err_sequencer
  import ces_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chain_start,
  input  logic          desc_avail,
  input  logic          cont_on_err,
  input  logic          rsp_valid,
  input  logic          rsp_err,
  input  logic          rsp_fmt_err,
  input  logic [AW-1:0] rsp_addr,
  output logic [2:0]    phase,
  output logic          stat_bus_err,
  output logic          stat_fail,
  output logic          stat_fmt_err,
  output logic          stwr_err,
  output logic          err_evt,
  output logic [AW-1:0] err_evt_addr,
  output logic [2:0]    err_evt_phase,
  output logic          chain_done,
  output logic          aborted
);

  phase_e phase_q;
  logic   ev_ok, ev_bus_err, ev_fmt_err, ev_stwr_err, ev_kill;
  logic   kill_pend, start_acc, desc_begin, end_clean, end_abort;

  ces_resp_decode dec_i (
    .phase_q     (phase_q),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_fmt_err (rsp_fmt_err),
    .cont_on_err (cont_on_err),
    .ev_ok       (ev_ok),
    .ev_bus_err  (ev_bus_err),
    .ev_fmt_err  (ev_fmt_err),
    .ev_stwr_err (ev_stwr_err),
    .ev_kill     (ev_kill)
  );

  ces_phase_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .chain_start (chain_start),
    .desc_avail  (desc_avail),
    .ev_ok       (ev_ok),
    .ev_bus_err  (ev_bus_err),
    .ev_fmt_err  (ev_fmt_err),
    .ev_stwr_err (ev_stwr_err),
    .ev_kill     (ev_kill),
    .kill_pend   (kill_pend),
    .phase_q     (phase_q),
    .start_acc   (start_acc),
    .desc_begin  (desc_begin),
    .end_clean   (end_clean),
    .end_abort   (end_abort)
  );

  ces_status_track st_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .desc_begin   (desc_begin),
    .ev_bus_err   (ev_bus_err),
    .ev_fmt_err   (ev_fmt_err),
    .ev_kill      (ev_kill),
    .stat_bus_err (stat_bus_err),
    .stat_fail    (stat_fail),
    .stat_fmt_err (stat_fmt_err),
    .kill_pend    (kill_pend)
  );

  ces_err_event #(.AW(AW)) evt_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_bus_err    (ev_bus_err),
    .ev_stwr_err   (ev_stwr_err),
    .phase_q       (phase_q),
    .rsp_addr      (rsp_addr),
    .err_evt       (err_evt),
    .err_evt_addr  (err_evt_addr),
    .err_evt_phase (err_evt_phase),
    .stwr_err      (stwr_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_done <= 1'b0;
      aborted    <= 1'b0;
    end else begin
      chain_done <= end_clean || end_abort;
      if (start_acc)      aborted <= 1'b0;
      else if (end_abort) aborted <= 1'b1;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/ces_checker.sv
module ces_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       chain_start,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       rsp_fmt_err,
  input logic [2:0] phase,
  input logic       stat_bus_err,
  input logic       stat_fail,
  input logic       stat_fmt_err,
  input logic       stwr_err,
  input logic       err_evt,
  input logic       chain_done,
  input logic       aborted,
  input logic       kill_pend
);

  logic busy;
  assign busy = (phase >= 3'd1) && (phase <= 3'd4);

  a_r4_early_err_to_stwr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err && (phase == 3'd1 || phase == 3'd2))
    |=> (phase == 3'd4 && stat_bus_err && stat_fail && kill_pend));

  a_r5_kill_ends_in_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && rsp_valid && !rsp_err && kill_pend) |=> (phase == 3'd5));

  a_r6_stwr_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    stwr_err |-> $past(phase == 3'd4 && rsp_valid && rsp_err));

  a_r7_evt_source: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> $past(rsp_valid && rsp_err && busy));

  a_r8_fmt_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && rsp_valid && !rsp_err && rsp_fmt_err)
    |=> (phase == 3'd4 && !err_evt && stat_fmt_err && stat_fail && !stat_bus_err));

  a_r9_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd5) |=> (phase == 3'd0));

  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> (phase == 3'd0 || phase == 3'd5));

  a_r9_aborted_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aborted) |-> (phase == 3'd1));

  a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0 && !chain_start) |=> (phase == 3'd0));

endmodule

bind chain_err_sequencer ces_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .chain_start  (chain_start),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .rsp_fmt_err  (rsp_fmt_err),
  .phase        (phase),
  .stat_bus_err (stat_bus_err),
  .stat_fail    (stat_fail),
  .stat_fmt_err (stat_fmt_err),
  .stwr_err     (stwr_err),
  .err_evt      (err_evt),
  .chain_done   (chain_done),
  .aborted      (aborted),
  .kill_pend    (kill_pend)
);

// File: tb/chain_err_sequencer_tb.sv
module chain_err_sequencer_tb_top;

  localparam int AW = 32;
  localparam logic [2:0] IDLE = 3'd0, FETCH = 3'd1, SYNC = 3'd2, EXEC = 3'd3,
                         STWR = 3'd4, ABRT = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chain_start = 1'b0, desc_avail = 1'b0, cont_on_err = 1'b0;
  logic          rsp_valid = 1'b0, rsp_err = 1'b0, rsp_fmt_err = 1'b0;
  logic [AW-1:0] rsp_addr = '0;
  logic [2:0]    phase, err_evt_phase;
  logic          stat_bus_err, stat_fail, stat_fmt_err, stwr_err, err_evt;
  logic          chain_done, aborted;
  logic [AW-1:0] err_evt_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  chain_err_sequencer #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .chain_start(chain_start), .desc_avail(desc_avail),
    .cont_on_err(cont_on_err), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_fmt_err(rsp_fmt_err), .rsp_addr(rsp_addr), .phase(phase),
    .stat_bus_err(stat_bus_err), .stat_fail(stat_fail), .stat_fmt_err(stat_fmt_err),
    .stwr_err(stwr_err), .err_evt(err_evt), .err_evt_addr(err_evt_addr),
    .err_evt_phase(err_evt_phase), .chain_done(chain_done), .aborted(aborted)
  );

  task automatic chk(input string req, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive one response for one cycle; return at the next negedge (results visible).
  task automatic respond(input logic err, input logic fmt, input logic [AW-1:0] addr);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_err = err; rsp_fmt_err = fmt; rsp_addr = addr;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0; rsp_fmt_err = 1'b0; rsp_addr = '0;
  endtask

  task automatic start_chain();
    @(negedge clk);
    chain_start = 1'b1;
    @(negedge clk);
    chain_start = 1'b0;
    chk("R2", "phase after start", AW'(phase), AW'(FETCH));
  endtask

  task automatic t_reset();
    chk("R1", "phase", AW'(phase), AW'(IDLE));
    chk("R1", "err_evt", AW'(err_evt), 0);
    chk("R1", "chain_done", AW'(chain_done), 0);
    chk("R1", "aborted", AW'(aborted), 0);
    chk("R1", "flags", AW'({stat_bus_err, stat_fail, stat_fmt_err, stwr_err}), 0);
  endtask

  task automatic t_clean_chain();
    desc_avail = 1'b1;
    start_chain();
    respond(0, 0, 0); chk("R2", "fetch->sync", AW'(phase), AW'(SYNC));
    respond(0, 0, 0); chk("R2", "sync->exec", AW'(phase), AW'(EXEC));
    respond(0, 0, 0); chk("R2", "exec->stwr", AW'(phase), AW'(STWR));
    chk("R2", "clean flags", AW'({stat_bus_err, stat_fail, stat_fmt_err}), 0);
    respond(0, 0, 0); chk("R3", "next desc", AW'(phase), AW'(FETCH));
    chk("R3", "no done mid chain", AW'(chain_done), 0);
    desc_avail = 1'b0;
    repeat (3) respond(0, 0, 0);
    respond(0, 0, 0);
    chk("R3", "end phase", AW'(phase), AW'(IDLE));
    chk("R3", "chain_done", AW'(chain_done), 1);
    chk("R3", "aborted", AW'(aborted), 0);
    @(negedge clk);
    chk("R3", "done pulse width", AW'(chain_done), 0);
  endtask

  task automatic t_early_err(input logic [2:0] where, input logic [AW-1:0] addr);
    cont_on_err = 1'b1; desc_avail = 1'b1;
    start_chain();
    if (where == SYNC) respond(0, 0, 0);
    respond(1, 0, addr);
    chk("R4", "jump to stwr", AW'(phase), AW'(STWR));
    chk("R4", "bus_err/fail", AW'({stat_bus_err, stat_fail, stat_fmt_err}), AW'(3'b110));
    chk("R7", "err_evt", AW'(err_evt), 1);
    chk("R7", "evt addr", err_evt_addr, addr);
    chk("R7", "evt phase", AW'(err_evt_phase), AW'(where));
    @(negedge clk);
    chk("R7", "evt one cycle", AW'(err_evt), 0);
    respond(0, 0, 0);
    chk("R4", "abort despite cont", AW'(phase), AW'(ABRT));
    chk("R9", "done at abort", AW'(chain_done), 1);
    chk("R9", "aborted set", AW'(aborted), 1);
    @(negedge clk);
    chk("R9", "abort one cycle", AW'(phase), AW'(IDLE));
    chk("R9", "aborted held", AW'(aborted), 1);
  endtask

  task automatic t_exec_err(input logic cont);
    cont_on_err = cont; desc_avail = 1'b1;
    start_chain();
    chk("R9", "aborted cleared by start", AW'(aborted), 0);
    repeat (2) respond(0, 0, 0);
    respond(1, 0, 32'h0000_3C00);
    chk("R5", "exec err to stwr", AW'(phase), AW'(STWR));
    chk("R5", "exec flags", AW'({stat_bus_err, stat_fail}), AW'(2'b11));
    chk("R7", "exec evt phase", AW'(err_evt_phase), AW'(EXEC));
    cont_on_err = ~cont;  // value at the error must rule
    respond(0, 0, 0);
    chk("R5", "exec outcome", AW'(phase), cont ? AW'(FETCH) : AW'(ABRT));
    chk("R5", "aborted", AW'(aborted), AW'(!cont));
    if (cont) begin
      chk("R10", "flags cleared on fetch", AW'({stat_bus_err, stat_fail}), 0);
      desc_avail = 1'b0;
      repeat (4) respond(0, 0, 0);
      chk("R3", "clean end after continue", AW'(phase), AW'(IDLE));
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic t_stwr_err(input logic cont);
    cont_on_err = cont; desc_avail = 1'b0;
    start_chain();
    repeat (3) respond(0, 0, 0);
    respond(1, 0, 32'hDEAD_0040);
    chk("R6", "stwr_err pulse", AW'(stwr_err), 1);
    chk("R6", "no descriptor flags", AW'({stat_bus_err, stat_fail}), 0);
    chk("R7", "stwr evt phase", AW'(err_evt_phase), AW'(STWR));
    chk("R7", "stwr evt addr", err_evt_addr, 32'hDEAD_0040);
    chk("R6", "stwr outcome", AW'(phase), cont ? AW'(IDLE) : AW'(ABRT));
    chk("R6", "done pulse", AW'(chain_done), 1);
    chk("R6", "aborted", AW'(aborted), AW'(!cont));
    @(negedge clk);
    chk("R6", "stwr_err one cycle", AW'(stwr_err), 0);
  endtask

  task automatic t_fmt_err();
    cont_on_err = 1'b1; desc_avail = 1'b1;
    start_chain();
    respond(0, 1, 32'h55);
    chk("R8", "fmt to stwr", AW'(phase), AW'(STWR));
    chk("R8", "fmt flags", AW'({stat_bus_err, stat_fail, stat_fmt_err}), AW'(3'b011));
    chk("R8", "no event", AW'(err_evt), 0);
    respond(0, 0, 0);
    chk("R8", "fmt aborts", AW'(phase), AW'(ABRT));
    @(negedge clk);
  endtask

  task automatic t_ignore();
    // aborted is 1 here from the previous scenario
    respond(1, 0, 32'h77);
    chk("R10", "idle ignores rsp", AW'(phase), AW'(IDLE));
    chk("R10", "idle no event", AW'(err_evt), 0);
    chk("R10", "aborted kept", AW'(aborted), 1);
    desc_avail = 1'b1; cont_on_err = 1'b0;
    start_chain();
    respond(0, 0, 0);
    @(negedge clk); chain_start = 1'b1;
    @(negedge clk); chain_start = 1'b0;
    chk("R10", "start ignored in sync", AW'(phase), AW'(SYNC));
    respond(0, 1, 0);
    chk("R8", "fmt ignored in sync", AW'(phase), AW'(EXEC));
    chk("R8", "fmt flag stays 0", AW'(stat_fmt_err), 0);
    desc_avail = 1'b0;
    repeat (2) respond(0, 0, 0);
    chk("R3", "ignore test ends", AW'(phase), AW'(IDLE));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_chain();
    t_early_err(FETCH, 32'h0000_1234);
    t_early_err(SYNC, 32'h0BAD_F00D);
    t_exec_err(1'b0);
    t_exec_err(1'b1);
    t_stwr_err(1'b0);
    t_stwr_err(1'b1);
    t_fmt_err();
    t_ignore();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule